// File: doc/BRIEF.md
# Bit-serial Montgomery multiplier

This block computes the Montgomery product `a * b * 2^-W mod N` for W-bit operands (W = 256 by default) and an odd modulus N. It works in radix 2 and needs no precomputed modulus inverse. Each clock cycle it consumes one bit of `a`, starting from the least significant bit. On that bit it conditionally adds `b` to a wide accumulator. It then adds N whenever the running sum is odd, which makes the sum even, and halves the result. When the last bit has been processed, a single conditional subtraction of N brings the value into the range [0, N).

A caller offers an operation on a valid/ready input channel. The block accepts it only while idle, captures N, `a` and `b` at that moment, and then runs for exactly W cycles. The result is held on a valid/ready output channel. It stays valid and unchanged for as long as the consumer holds `out_ready` low. That back-pressure stalls the block, and it does not accept the next operation until the result has been taken. Inputs need not be in Montgomery form. Domain conversion is left to the caller.

Top module: `mont_mul_serial`

## Requirements
- R1: After reset, `in_ready` is 1 and `out_valid` is 0.
- R2: `in_ready` is high only while the block is idle. An operation is transferred on a rising clock edge where `in_valid` and `in_ready` are both 1, and `in_ready` is 0 in the following cycle.
- R3: When `out_valid` is 1, `out_res` equals `a * b * 2^-W mod N` for the transferred operands. This holds for odd N with a < N and b < N.
- R4: `out_valid` rises exactly W clock cycles after the transfer edge.
- R5: N, `a` and `b` are captured at the transfer edge. Changes on `in_mod`, `in_a` and `in_b` after that edge have no effect on the result.
- R6: While `out_valid` is 1 and `out_ready` is 0, `out_valid` stays 1 and `out_res` does not change. After an edge with both signals at 1, `out_valid` is 0 and `in_ready` is 1.
- R7: Every operation starts from an accumulator of zero, so a result does not depend on earlier operations.
- R8: While `out_valid` is 1, `out_res` is below the captured modulus N. One final subtraction is enough for this.
- R9: `in_valid` asserted while the block is computing or holding a result is ignored. It neither restarts nor alters the running operation.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Caller offers an operation |
| in_ready | output | 1 | Block is idle and will accept an operation |
| in_mod | input | W | Modulus N, must be odd |
| in_a | input | W | Multiplier operand, scanned one bit per cycle from bit 0 |
| in_b | input | W | Multiplicand operand |
| out_valid | output | 1 | Result available |
| out_ready | input | 1 | Consumer takes the result |
| out_res | output | W | Montgomery product, below N |

## Verification
Zero and unit multipliers show whether the scan of `a` and the parity-driven addition of N are correct without the `b` path hiding them. The all-ones odd modulus with N-1 operands drives the accumulator to its upper bound, which exposes a truncated accumulator or a missing final subtraction. A tiny modulus exposes faults in the low-order bits. Pseudo-random operands under several moduli cover the general case. Back-to-back runs, with junk on the inputs and `in_valid` held during each run, separate a correct capture-and-clear from a design that reuses state or samples its inputs late.

// File: rtl/mm_pkg.sv
package mm_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_CALC = 2'd1,
    ST_DONE = 2'd2
  } mm_state_e;
endpackage

// File: rtl/mm_ctrl.sv
// Sequencer: idle -> W iteration cycles -> hold result until taken.
module mm_ctrl
  import mm_pkg::*;
#(
  parameter int W = 256
) (
  input  logic clk,
  input  logic rst_n,
  input  logic in_valid,
  input  logic out_ready,
  output logic in_ready,
  output logic out_valid,
  output logic load,
  output logic step
);
  localparam int CW = (W > 1) ? $clog2(W) : 1;
  localparam logic [CW-1:0] LAST = CW'(W - 1);

  mm_state_e       state_q, state_d;
  logic [CW-1:0]   iter_q;

  assign in_ready  = (state_q == ST_IDLE);
  assign out_valid = (state_q == ST_DONE);
  assign load      = in_valid && in_ready;
  assign step      = (state_q == ST_CALC);

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE: if (load)            state_d = ST_CALC;
      ST_CALC: if (iter_q == LAST)  state_d = ST_DONE;
      ST_DONE: if (out_ready)       state_d = ST_IDLE;
      default:                      state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      iter_q  <= '0;
    end else begin
      state_q <= state_d;
      if (load)      iter_q <= '0;
      else if (step) iter_q <= iter_q + 1'b1;
    end
  end
endmodule

// File: rtl/mm_step.sv
// One radix-2 iteration: add b on the scanned bit, make even with N, halve.
module mm_step #(
  parameter int W = 256
) (
  input  logic [W+1:0] m_i,
  input  logic [W-1:0] b_i,
  input  logic [W-1:0] n_i,
  input  logic         abit_i,
  output logic [W+1:0] m_o
);
  localparam int AW = W + 2;

  logic [AW-1:0] add_b, sum_b, add_n, sum_n;

  always_comb begin
    add_b = abit_i ? {2'b00, b_i} : '0;
    sum_b = m_i + add_b;
    add_n = sum_b[0] ? {2'b00, n_i} : '0;
    sum_n = sum_b + add_n;
    m_o   = {1'b0, sum_n[AW-1:1]};
  end
endmodule

// File: rtl/mm_final_sub.sv
// Single conditional subtraction bringing the accumulator below N.
module mm_final_sub #(
  parameter int W = 256
) (
  input  logic [W+1:0] m_i,
  input  logic [W-1:0] n_i,
  output logic [W-1:0] res_o
);
  localparam int AW = W + 2;

  logic [AW:0] diff;
  logic        below;

  always_comb begin
    diff  = {1'b0, m_i} - {3'b000, n_i};
    below = diff[AW];
    res_o = below ? m_i[W-1:0] : diff[W-1:0];
  end
endmodule

// File: rtl/mont_mul_serial.sv
module mont_mul_serial #(
  parameter int W = 256
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         in_valid,
  output logic         in_ready,
  input  logic [W-1:0] in_mod,
  input  logic [W-1:0] in_a,
  input  logic [W-1:0] in_b,
  output logic         out_valid,
  input  logic         out_ready,
  output logic [W-1:0] out_res
);
  localparam int AW = W + 2;

  logic          load, step;
  logic [W-1:0]  n_q, a_q, b_q;
  logic [AW-1:0] m_q, m_nxt;

  mm_ctrl #(.W(W)) u_ctrl (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .out_ready (out_ready),
    .in_ready  (in_ready),
    .out_valid (out_valid),
    .load      (load),
    .step      (step)
  );

  mm_step #(.W(W)) u_step (
    .m_i    (m_q),
    .b_i    (b_q),
    .n_i    (n_q),
    .abit_i (a_q[0]),
    .m_o    (m_nxt)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      n_q <= '0;
      a_q <= '0;
      b_q <= '0;
      m_q <= '0;
    end else if (load) begin
      n_q <= in_mod;
      a_q <= in_a;
      b_q <= in_b;
      m_q <= '0;
    end else if (step) begin
      a_q <= a_q >> 1;
      m_q <= m_nxt;
    end
  end

  mm_final_sub #(.W(W)) u_sub (
    .m_i   (m_q),
    .n_i   (n_q),
    .res_o (out_res)
  );
endmodule

// File: rtl/mont_mul_serial_chk.sv
module mont_mul_serial_chk #(
  parameter int W = 256
) (
  input logic         clk,
  input logic         rst_n,
  input logic         in_valid,
  input logic         in_ready,
  input logic         out_valid,
  input logic         out_ready,
  input logic [W-1:0] out_res,
  input logic [W-1:0] mod_q
);
  localparam int LW = $clog2(W + 1) + 1;

  logic          busy;
  logic [LW-1:0] lat;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy <= 1'b0;
      lat  <= '0;
    end else if (in_valid && in_ready) begin
      busy <= 1'b1;
      lat  <= '0;
    end else if (busy && !out_valid) begin
      lat <= lat + 1'b1;
    end else if (out_valid) begin
      busy <= 1'b0;
    end
  end

  a_r2_accept_busy: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready) |=> (!in_ready && !out_valid));

  a_r4_latency: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(out_valid) |-> (lat == LW'(W)));

  a_r6_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_res)));

  a_r6_release: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_ready) |=> (in_ready && !out_valid));

  a_r8_below_mod: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> (out_res < mod_q));
endmodule

bind mont_mul_serial mont_mul_serial_chk #(.W(W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .in_valid  (in_valid),
  .in_ready  (in_ready),
  .out_valid (out_valid),
  .out_ready (out_ready),
  .out_res   (out_res),
  .mod_q     (n_q)
);

// File: tb/mont_mul_serial_test.sv
`timescale 1ns/1ps
module mont_mul_serial_test;
  localparam int W = 256;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         in_valid = 1'b0;
  logic         in_ready;
  logic [W-1:0] in_mod = '0, in_a = '0, in_b = '0;
  logic         out_valid;
  logic         out_ready = 1'b0;
  logic [W-1:0] out_res;

  int  n_tests = 0;
  int  n_fail  = 0;
  bit  finished = 1'b0;
  logic [63:0] seed = 64'h9E3779B97F4A7C15;

  always #2.5 clk = ~clk;

  mont_mul_serial #(.W(W)) uut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_mod(in_mod), .in_a(in_a), .in_b(in_b),
    .out_valid(out_valid), .out_ready(out_ready), .out_res(out_res)
  );

  task automatic chk(input bit ok, input string req,
                     input logic [W-1:0] act, input logic [W-1:0] exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // Reference: reduce a*b mod N, then halve modulo N W times.
  function automatic logic [W-1:0] ref_mont(input logic [W-1:0] n,
                                            input logic [W-1:0] a,
                                            input logic [W-1:0] b);
    logic [2*W-1:0] prod, rem;
    logic [W:0]     r;
    prod = {{W{1'b0}}, a} * {{W{1'b0}}, b};
    rem  = prod % {{W{1'b0}}, n};
    r    = rem[W:0];
    for (int i = 0; i < W; i++) begin
      if (r[0]) r = (r + {1'b0, n}) >> 1;
      else      r = r >> 1;
    end
    return r[W-1:0];
  endfunction

  function automatic logic [63:0] xs64(input logic [63:0] s);
    logic [63:0] x;
    x = s;
    x = x ^ (x << 13);
    x = x ^ (x >> 7);
    x = x ^ (x << 17);
    return x;
  endfunction

  task automatic rnd_wide(output logic [W-1:0] v);
    for (int i = 0; i < W / 64; i++) begin
      seed = xs64(seed);
      v[i*64 +: 64] = seed;
    end
  endtask

  task automatic run_op(input logic [W-1:0] n, input logic [W-1:0] a,
                        input logic [W-1:0] b, input bit scramble,
                        input string tag);
    logic [W-1:0] exp, held, junk;
    int cyc;
    exp = ref_mont(n, a, b);
    @(negedge clk);
    chk(in_ready === 1'b1, {"R2 ready before ", tag}, W'(in_ready), W'(1));
    in_mod = n; in_a = a; in_b = b; in_valid = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
    chk(in_ready === 1'b0, {"R2 busy after transfer ", tag}, W'(in_ready), W'(0));
    cyc = 0;
    while (!out_valid && cyc < W + 20) begin
      if (scramble) begin  // R5 / R9: junk operands and in_valid while busy
        rnd_wide(junk); in_mod = junk | 1;
        rnd_wide(junk); in_a = junk;
        rnd_wide(junk); in_b = junk;
        in_valid = 1'b1;
      end
      @(negedge clk);
      cyc++;
    end
    in_valid = 1'b0;
    chk(cyc == W, {"R4 latency ", tag}, W'(cyc), W'(W));
    chk(out_res === exp, {"R3 R5 R7 R9 value ", tag}, out_res, exp);
    chk(out_res < n, {"R8 below modulus ", tag}, out_res, n);
    held = out_res;
    repeat (3) @(negedge clk);
    chk(out_valid === 1'b1 && out_res === held, {"R6 hold ", tag}, out_res, held);
    out_ready = 1'b1;
    @(negedge clk);
    out_ready = 1'b0;
    chk(out_valid === 1'b0 && in_ready === 1'b1, {"R6 release ", tag},
        W'({out_valid, in_ready}), W'(2'b01));
  endtask

  task automatic t_reset;
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    chk(in_ready === 1'b1 && out_valid === 1'b0, "R1 reset state",
        W'({in_ready, out_valid}), W'(2'b10));
    rst_n = 1'b1;
    @(negedge clk);
    chk(in_ready === 1'b1 && out_valid === 1'b0, "R1 after release",
        W'({in_ready, out_valid}), W'(2'b10));
  endtask

  task automatic t_edges;
    logic [W-1:0] n;
    n = {W{1'b1}};
    run_op(n, n - 1, n - 1, 1'b0, "max modulus");
    run_op(n, '0, n - 1, 1'b0, "zero a");
    run_op(n - 2, 1, 1, 1'b0, "unit operands");
    run_op(W'(3), W'(2), W'(2), 1'b0, "tiny modulus");
  endtask

  task automatic t_random;
    logic [W-1:0] n, a, b;
    for (int k = 0; k < 6; k++) begin
      rnd_wide(n); n = n | 1;
      if (k[0]) n[W-1] = 1'b1;
      rnd_wide(a); a = a % n;
      rnd_wide(b); b = b % n;
      run_op(n, a, b, k[1], $sformatf("random %0d", k));
    end
  endtask

  task automatic t_back_to_back;  // R7: large result first, then small one
    logic [W-1:0] n;
    n = {W{1'b1}} - 64'd58;
    run_op(n, n - 3, n - 5, 1'b1, "b2b first");
    run_op(n, W'(1), '0, 1'b1, "b2b second");
  endtask

  task automatic summary;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
  endtask

  initial begin
    t_reset();
    t_edges();
    t_random();
    t_back_to_back();
    finished = 1'b1;
    summary();
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      n_tests++;
      n_fail++;
      $display("FAIL watchdog actual=timeout expected=completion");
      summary();
      $finish;
    end
  end
endmodule